// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one DMA channel that walks a chain of descriptors in memory and copies data for each one. Software places a descriptor pointer in the channel, sets the enable bit and writes the doorbell register. The channel then reads an eight-word descriptor and checks its valid flag. For a valid descriptor it copies the programmed number of bytes from the source address to the destination address, one 32-bit word at a time, with both addresses incrementing. It then performs the completion action the descriptor selects, flags an interrupt, and moves on to the descriptor named by the next-pointer word.

A descriptor occupies 32 bytes on a 32-byte boundary. Its words, by index, are: 0 command, 1 byte count, 2 source address, 3 unused, 4 destination address, 5 unused, 6 completion status, 7 link. A descriptor whose valid flag is clear parks the channel in the halted state. The next doorbell write fetches again from the same pointer, so software can fill in a parked descriptor and resume the chain.

The channel has a small register port with one-cycle registered reads, and a single-word memory master. The master holds a request until it sees a grant. Read data arrives on the cycle after the grant.

Top module: `dchain_dma`

## Requirements
- R1: After reset the channel is halted: the state register (word 4) reads 1, the interrupt register (word 3) reads 0, `irq` is low and `mem_req` is low.
- R2: A write of any value to the doorbell register (word 2) while the control register (word 0) bit 0 is set starts the channel. It reads the eight descriptor words, at byte offsets 0 to 28 from the pointer, before it moves any data.
- R3: For a valid descriptor (command bit 31 set), the channel copies ceil(N/4) words, where N is the link-free byte count in word 1 bits 21:0. The words go from consecutive source addresses to consecutive destination addresses. No word beyond that count is written, and N = 0 copies nothing.
- R4: Command bits 1:0 select what goes into descriptor word 6 (byte offset 24) once the copy ends. 0 leaves it untouched. 1 stores the channel state, 0x6 while running. 2 stores the command word with bit 31 cleared. 3 stores the bytes still outstanding, which is 0 after a full copy.
- R5: When command bit 2 is set, the channel rewrites descriptor word 0 as the command word with bit 31 cleared once the copy ends. When bit 2 is clear, word 0 is left unchanged.
- R6: Each finished descriptor sets bit 0 of the interrupt register, whatever its command bit 8. `irq` rises only when command bit 8 was set. Writing 1 to bit 0 of the interrupt register clears both.
- R7: After a descriptor finishes, the channel fetches the next one from (link word bits 26:0) shifted left by 5. Link bits 31:27 are ignored. The pointer register (word 1) reads the address of the descriptor currently loaded.
- R8: A fetched descriptor with bit 31 clear moves no data and halts the channel, with the state register reading 1. The next doorbell write fetches again from the same pointer.
- R9: Clearing control bit 0 during a copy halts the channel after the word in flight and writes no completion data. The channel flags no interrupt. The state register reads 3, and the remaining-count register (word 5) reads N minus 4 times the number of words copied.
- R10: A memory request keeps `mem_req`, `mem_we` and `mem_addr` steady until the cycle of `mem_gnt`. All addresses are word aligned.
- R11: A doorbell write while control bit 0 is clear starts nothing. Only the doorbell-seen flag (state bit 2) is set, so the state register reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_addr` |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a read grant |
| irq | output | 1 | Interrupt, gated by each descriptor's enable bit |

## Verification
A corrupted word counter shows up as a destination region that is one word short or one word long. It also shows in the number of read grants, which the bench compares with 8 + ceil(N/4) + 8 for every descriptor. A wrong pointer or link decode leaves the pointer register at something other than the terminator address as soon as the chain halts. A stuck state machine never returns to halted, which the polling loop turns into a failure within a few thousand cycles. A write-back from the wrong state appears in the status word or in word 0 on the same run.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int DW = 32;

  // descriptor word indices
  localparam int W_CMD0 = 0;
  localparam int W_CMD1 = 1;
  localparam int W_SRC  = 2;
  localparam int W_DST  = 4;
  localparam int W_STAT = 6;
  localparam int W_LINK = 7;
  localparam int DESC_LAST = 7;

  // command word bits
  localparam int B_VALID = 31;
  localparam int B_IE    = 8;
  localparam int B_CLRV  = 2;
  localparam logic [DW-1:0] VALID_MASK = 32'h8000_0000;

  // register word indices
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_PTR    = 3'd1;
  localparam logic [2:0] RA_BELL   = 3'd2;
  localparam logic [2:0] RA_IRQ    = 3'd3;
  localparam logic [2:0] RA_STATE  = 3'd4;
  localparam logic [2:0] RA_REMAIN = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_CHECK, S_RD, S_RDW, S_WR, S_STAT, S_CLRV, S_FIN
  } eng_st_t;
endpackage

// File: rtl/dchain_regs.sv
module dchain_regs
  import dchain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_o,
  output logic              en_o,
  output logic              bell_o,
  output logic              ptr_wr_o,
  output logic [ADDR_W-1:0] ptr_wdata_o,
  input  logic              done_i,
  input  logic              done_ie_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [BC_W-1:0]   remain_i,
  input  logic              halted_i,
  input  logic              dvalid_i,
  input  logic              dbell_i
);
  logic pend;
  logic irq_q;
  logic en_q;
  logic [DW-1:0] rd_q;

  assign bell_o      = reg_we && (reg_addr == RA_BELL);
  assign ptr_wr_o    = reg_we && (reg_addr == RA_PTR);
  assign ptr_wdata_o = reg_wdata[ADDR_W-1:0];
  assign en_o        = en_q;
  assign irq_o       = irq_q;
  assign reg_rdata   = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pend  <= 1'b0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CTRL) en_q <= reg_wdata[0];
      if (reg_we && reg_addr == RA_IRQ && reg_wdata[0]) begin
        pend  <= 1'b0;
        irq_q <= 1'b0;
      end
      if (done_i) begin
        pend <= 1'b1;
        if (done_ie_i) irq_q <= 1'b1;
      end
      case (reg_addr)
        RA_CTRL:   rd_q <= {{(DW-1){1'b0}}, en_q};
        RA_PTR:    rd_q <= DW'(ptr_i);
        RA_IRQ:    rd_q <= {{(DW-1){1'b0}}, pend};
        RA_STATE:  rd_q <= {{(DW-3){1'b0}}, dbell_i, dvalid_i, halted_i};
        RA_REMAIN: rd_q <= DW'(remain_i);
        default:   rd_q <= '0;
      endcase
    end
  end

  // R6: every completion leaves the pending flag set
  p_done_sets_pend_r6: assert property (@(posedge clk) disable iff (rst)
    done_i |=> pend);
  // R6: an enabled completion raises the interrupt line
  p_done_raises_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (done_i && done_ie_i) |=> irq_o);
endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
  import dchain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bell_i,
  input  logic              ptr_wr_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic              done_ie_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [BC_W-1:0]   remain_o,
  output logic              halted_o,
  output logic              dvalid_o,
  output logic              dbell_o
);
  localparam int PTR_LSB = 5;
  localparam int LINK_W  = ADDR_W - PTR_LSB;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STAT_O = ADDR_W'(W_STAT * 4);
  localparam logic [BC_W-1:0]   BSTEP  = BC_W'(4);

  eng_st_t st;
  logic [2:0]        idx;
  logic [ADDR_W-1:0] ptr, src, dst;
  logic [DW-1:0]     cmd0, dbuf, stat_val;
  logic [BC_W-1:0]   cmd1, remain, rem_dec;
  logic [LINK_W-1:0] link;
  logic              dvalid, dbell, done_q, done_ie_q;
  logic              unused_ptr_lsb;

  assign unused_ptr_lsb = ^ptr_wdata_i[PTR_LSB-1:0];
  assign rem_dec   = (remain > BSTEP) ? (remain - BSTEP) : '0;
  assign halted_o  = (st == S_IDLE);
  assign dvalid_o  = dvalid;
  assign dbell_o   = dbell;
  assign ptr_o     = ptr;
  assign remain_o  = remain;
  assign done_o    = done_q;
  assign done_ie_o = done_ie_q;

  always_comb begin
    case (cmd0[1:0])
      2'd1:    stat_val = {{(DW-3){1'b0}}, dbell, dvalid, 1'b0};
      2'd2:    stat_val = cmd0 & ~VALID_MASK;
      2'd3:    stat_val = DW'(remain);
      default: stat_val = cmd0;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = dbuf;
    case (st)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr + ADDR_W'({idx, 2'b00});
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src;
      end
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst;
      end
      S_STAT: begin
        mem_req_o   = (cmd0[1:0] != 2'd0);
        mem_we_o    = (cmd0[1:0] != 2'd0);
        mem_addr_o  = ptr + STAT_O;
        mem_wdata_o = stat_val;
      end
      S_CLRV: begin
        mem_req_o   = cmd0[B_CLRV];
        mem_we_o    = cmd0[B_CLRV];
        mem_wdata_o = cmd0 & ~VALID_MASK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      ptr       <= '0;
      src       <= '0;
      dst       <= '0;
      cmd0      <= '0;
      cmd1      <= '0;
      link      <= '0;
      dbuf      <= '0;
      remain    <= '0;
      dvalid    <= 1'b0;
      dbell     <= 1'b0;
      done_q    <= 1'b0;
      done_ie_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bell_i) dbell <= 1'b1;
      case (st)
        S_IDLE: begin
          if (ptr_wr_i) ptr <= {ptr_wdata_i[ADDR_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
          if (bell_i && en_i) begin
            st  <= S_FETCH;
            idx <= '0;
          end
        end
        S_FETCH: if (mem_gnt_i) st <= S_FWAIT;
        S_FWAIT: begin
          case (int'(idx))
            W_CMD0:  cmd0 <= mem_rdata_i;
            W_CMD1:  cmd1 <= mem_rdata_i[BC_W-1:0];
            W_SRC:   src  <= mem_rdata_i[ADDR_W-1:0];
            W_DST:   dst  <= mem_rdata_i[ADDR_W-1:0];
            W_LINK:  link <= mem_rdata_i[LINK_W-1:0];
            default: ;
          endcase
          if (int'(idx) == DESC_LAST) st <= S_CHECK;
          else begin
            idx <= idx + 3'd1;
            st  <= S_FETCH;
          end
        end
        S_CHECK: begin
          remain <= cmd1;
          dvalid <= cmd0[B_VALID];
          if (!cmd0[B_VALID] || !en_i) begin
            st <= S_IDLE;
            if (!bell_i) dbell <= 1'b0;
          end else if (cmd1 == '0) st <= S_STAT;
          else st <= S_RD;
        end
        S_RD: if (mem_gnt_i) begin
          src <= src + STEP;
          st  <= S_RDW;
        end
        S_RDW: begin
          dbuf <= mem_rdata_i;
          st   <= S_WR;
        end
        S_WR: if (mem_gnt_i) begin
          dst    <= dst + STEP;
          remain <= rem_dec;
          if (!en_i) begin
            st <= S_IDLE;
            if (!bell_i) dbell <= 1'b0;
          end else if (rem_dec == '0) st <= S_STAT;
          else st <= S_RD;
        end
        S_STAT: if (cmd0[1:0] == 2'd0 || mem_gnt_i) st <= S_CLRV;
        S_CLRV: if (!cmd0[B_CLRV] || mem_gnt_i) st <= S_FIN;
        S_FIN: begin
          done_q    <= 1'b1;
          done_ie_q <= cmd0[B_IE];
          ptr       <= {link, {PTR_LSB{1'b0}}};
          idx       <= '0;
          st        <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: a stalled request stays put until granted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R10: word-aligned accesses only
  p_word_align_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  // R1: a halted channel never touches memory
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !mem_req_o);
  // R6: completion is a single-cycle event
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);
  logic              en, bell, ptr_wr, done, done_ie, halted, dvalid, dbell;
  logic [ADDR_W-1:0] ptr_wdata, ptr;
  logic [BC_W-1:0]   remain;

  dchain_regs #(.ADDR_W(ADDR_W), .BC_W(BC_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq),
    .en_o(en), .bell_o(bell), .ptr_wr_o(ptr_wr), .ptr_wdata_o(ptr_wdata),
    .done_i(done), .done_ie_i(done_ie), .ptr_i(ptr), .remain_i(remain),
    .halted_i(halted), .dvalid_i(dvalid), .dbell_i(dbell)
  );

  dchain_engine #(.ADDR_W(ADDR_W), .BC_W(BC_W)) u_eng (
    .clk(clk), .rst(rst), .en_i(en), .bell_i(bell), .ptr_wr_i(ptr_wr),
    .ptr_wdata_i(ptr_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .done_o(done), .done_ie_o(done_ie),
    .ptr_o(ptr), .remain_o(remain), .halted_o(halted), .dvalid_o(dvalid),
    .dbell_o(dbell)
  );
endmodule

// File: tb/sim_dchain_dma.sv
`timescale 1ns/1ps
module sim_dchain_dma;
  localparam logic [31:0] POISON = 32'hDEAD_BEEF;
  localparam int DESC_W = 64;   // 0x100
  localparam int TERM_W = 128;  // 0x200
  localparam int SRC_W  = 256;  // 0x400
  localparam int DST_W  = 512;  // 0x800

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_gnt, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic [31:0] mem [0:1023];
  logic [7:0] lfsr;
  logic stall = 1'b0;
  int rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  int checks = 0, errors = 0;
  logic hold_pend = 1'b0;
  logic [31:0] hold_addr = '0;

  always #2 clk = ~clk;

  dchain_dma u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_gnt = mem_req && (!stall || lfsr[0]);

  always @(posedge clk) begin
    if (rst) lfsr <= 8'hA5;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst && mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // R10 port monitor, sampled between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend && (!mem_req || mem_addr !== hold_addr)) hold_err = hold_err + 1;
      hold_pend = mem_req && !mem_gnt;
      hold_addr = mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_halt();
    logic [31:0] s;
    bit done = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4000 && !done; k++) begin
      rd(3'd4, s);
      if (s[0]) done = 1;
    end
    if (!done) chk("R2 channel never halted", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] pat(input int n, input int i);
    return {8'(n), 8'h5A, 16'(i)};
  endfunction

  task automatic fill(input int n, input int words_src, input int words_dst);
    for (int i = 0; i < words_src; i++) mem[SRC_W + i] = pat(n, i);
    for (int i = 0; i < words_dst; i++) mem[DST_W + i] = POISON;
  endtask

  task automatic put_desc(input int w, input logic [31:0] c0, input int bytes,
                          input logic [31:0] sa, input logic [31:0] da, input logic [31:0] nx);
    mem[w]   = c0;
    mem[w+1] = 32'(bytes);
    mem[w+2] = sa;
    mem[w+3] = 32'h0;
    mem[w+4] = da;
    mem[w+5] = 32'h0;
    mem[w+6] = POISON;
    mem[w+7] = nx;
  endtask

  initial begin
    logic [31:0] d;
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    int words, act, cv, ie, bytes, r0, copied;
    bit ok;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd4, d); chk("R1 state after reset", d, 32'h1);
    rd(3'd3, d); chk("R1 irq reg after reset", d, 32'h0);
    chk("R1 irq pin after reset", {31'b0, irq}, 32'h0);
    chk("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);

    // R11 doorbell with channel disabled
    fill(0, 8, 8);
    put_desc(DESC_W, 32'h8000_0000, 16, 32'h400, 32'h800, 32'h200 >> 5);
    mem[TERM_W] = 32'h0;
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h0);
    repeat (30) @(negedge clk);
    rd(3'd4, d); chk("R11 state after disabled doorbell", d, 32'h5);
    chk("R11 no memory traffic", 32'(rd_cnt + wr_cnt), 32'h0);
    chk("R11 destination untouched", mem[DST_W], POISON);

    // sweep: byte counts 0..75, every completion action, clear-valid and irq enable
    for (int n = 0; n < 16; n++) begin
      bytes = n * 5; words = (bytes + 3) / 4;
      act = n % 4; cv = (n / 4) % 2; ie = (n / 8) % 2;
      stall = n[0];
      fill(n, 24, 24);
      c0 = 32'h8000_0000 | 32'(ie << 8) | 32'(cv << 2) | 32'(act) | 32'h000A_0000;
      put_desc(DESC_W, c0, bytes, 32'h400, 32'h800, 32'h200 >> 5);
      r0 = rd_cnt;
      wr(3'd1, 32'h100);
      wr(3'd0, 32'h1);
      wr(3'd2, 32'h1234);
      wait_halt();
      chk($sformatf("R2 reads for bytes=%0d", bytes), 32'(rd_cnt - r0), 32'(16 + words));
      ok = 1;
      for (int i = 0; i < 24; i++)
        if (mem[DST_W + i] !== ((i < words) ? pat(n, i) : POISON)) ok = 0;
      chk($sformatf("R3 copy bytes=%0d", bytes), {31'b0, ok}, 32'h1);
      case (act)
        0: d = POISON;
        1: d = 32'h6;
        2: d = c0 & 32'h7FFF_FFFF;
        default: d = 32'h0;
      endcase
      chk($sformatf("R4 status action=%0d", act), mem[DESC_W + 6], d);
      chk($sformatf("R5 word0 clear-valid=%0d", cv), mem[DESC_W],
          cv ? (c0 & 32'h7FFF_FFFF) : c0);
      rd(3'd3, d); chk("R6 pending set", d, 32'h1);
      chk($sformatf("R6 irq pin ie=%0d", ie), {31'b0, irq}, 32'(ie));
      rd(3'd1, d); chk("R7 pointer at terminator", d, 32'h200);
      rd(3'd4, d); chk("R8 halted on invalid terminator", d, 32'h1);
      wr(3'd3, 32'h1);
      rd(3'd3, d); chk("R6 pending cleared", d, 32'h0);
      chk("R6 irq pin cleared", {31'b0, irq}, 32'h0);
    end

    // R7 chain of three scattered descriptors with junk in link upper bits
    stall = 1'b1;
    fill(40, 48, 48);
    put_desc(64, 32'h8000_0000, 8, 32'h400, 32'h800, 32'hF800_0000 | (32'h120 >> 5));
    put_desc(72, 32'h8000_0000, 8, 32'h440, 32'h840, 32'h4000_0000 | (32'h180 >> 5));
    put_desc(96, 32'h8000_0000, 6, 32'h480, 32'h880, 32'h200 >> 5);
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h0);
    wait_halt();
    for (int k = 0; k < 3; k++) begin
      ok = (mem[DST_W + 16*k] === pat(40, 16*k)) && (mem[DST_W + 16*k + 1] === pat(40, 16*k + 1))
           && (mem[DST_W + 16*k + 2] === POISON);
      chk($sformatf("R7 chain link %0d copied", k), {31'b0, ok}, 32'h1);
    end
    rd(3'd1, d); chk("R7 chain end pointer", d, 32'h200);
    rd(3'd3, d); chk("R6 pending after chain", d, 32'h1);
    wr(3'd3, 32'h1);

    // R8 parked descriptor, then resumed from the same pointer
    stall = 1'b0;
    fill(50, 8, 8);
    put_desc(DESC_W, 32'h0, 8, 32'h400, 32'h800, 32'h200 >> 5);
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h0);
    wait_halt();
    rd(3'd4, d); chk("R8 state parked", d, 32'h1);
    rd(3'd1, d); chk("R8 pointer kept", d, 32'h100);
    chk("R8 nothing copied", mem[DST_W], POISON);
    rd(3'd3, d); chk("R8 no completion", d, 32'h0);
    mem[DESC_W] = 32'h8000_0000;
    wr(3'd2, 32'h0);
    wait_halt();
    ok = (mem[DST_W] === pat(50, 0)) && (mem[DST_W + 1] === pat(50, 1)) && (mem[DST_W + 2] === POISON);
    chk("R8 resumed copy", {31'b0, ok}, 32'h1);
    rd(3'd1, d); chk("R8 resumed to terminator", d, 32'h200);
    wr(3'd3, 32'h1);

    // R9 enable cleared mid-copy
    stall = 1'b1;
    fill(60, 100, 128);
    put_desc(DESC_W, 32'h8000_0107, 400, 32'h400, 32'h800, 32'h200 >> 5);
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h0);
    repeat (80) @(negedge clk);
    wr(3'd0, 32'h0);
    wait_halt();
    copied = 0;
    while (copied < 100 && mem[DST_W + copied] === pat(60, copied)) copied++;
    chk("R9 stopped inside the copy", {31'b0, (copied > 0 && copied < 100)}, 32'h1);
    chk("R9 nothing past the boundary", mem[DST_W + copied], POISON);
    rd(3'd5, d); chk("R9 remaining count", d, 32'(400 - 4 * copied));
    chk("R9 no status write", mem[DESC_W + 6], POISON);
    chk("R9 word0 unchanged", mem[DESC_W], 32'h8000_0107);
    rd(3'd3, d); chk("R9 no completion", d, 32'h0);
    rd(3'd4, d); chk("R9 state after abort", d, 32'h3);

    chk("R10 request held until grant", 32'(hold_err), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule